// File: doc/BRIEF.md
# Banked Interrupt Status and Mask Controller

This block collects up to thirty interrupt sources into four eight-bit banks and presents them through a byte-wide register port. The banks are a low-priority interrupt bank, a high-priority interrupt bank, a DMA bank with six sources, and a fast-interrupt bank. Each bank has three registers:
- a status register that shows the source state;
- a request register that reads as status AND mask;
- a mask register, in which a 1 enables the source.

The low-priority bank latches rising edges of its sources. Software acknowledges a latched source by writing a 1 to the request offset, which acts as a clear register on write. The other three banks only sample the level of their sources, and a write to their request offset does nothing.

Two outputs go to the processor. The general interrupt line is the OR of the requests in the low-priority, high-priority and DMA banks. The fast-interrupt line is the OR of the requests in the fast-interrupt bank. Software masks and unmasks a source with a read-modify-write of the mask register.

Top module: `irq_bank_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, all status and mask registers are zero. Every read therefore returns 0, and `irq_o` and `fiq_o` are low until a mask bit is set.
- R2: `addr_i[5:4]` selects the bank: 0 low-priority, 1 high-priority, 2 DMA, 3 fast. `addr_i[3:0]` selects the register: 0x0 status, 0x4 request (on read), 0x8 mask. Any other offset reads 0. `rdata_o` is combinational from the current address and register state.
- R3: A write (`we_i` high at a rising clock edge) to offset 0x8 loads the mask of the selected bank from `wdata_i`. The new value reads back from the next cycle.
- R4: A read of offset 0x4 returns the bank's status AND mask.
- R5: A status bit of the low-priority bank is set by a rising edge of its source, seen between two successive clock samples. It stays set after the source falls. A source that is already high when reset is released counts as a rising edge.
- R6: In the low-priority bank, a write to offset 0x4 clears each status bit whose `wdata_i` bit is 1 and leaves bits written 0 unchanged. A rising edge in the same cycle keeps its bit set.
- R7: Status bits of the high-priority, DMA and fast banks equal the source level sampled at the previous clock edge. A write to their offset 0x4 has no effect.
- R8: Writes to offset 0x0 change no register in any bank.
- R9: DMA bits 7:6 read as zero in status, request and mask, even when 1s are written to them.
- R10: `irq_o` is high exactly when any request bit of the low-priority, high-priority or DMA bank is set. `fiq_o` is high exactly when any request bit of the fast bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_a_i | input | 8 | Low-priority sources (edge-latched) |
| src_b_i | input | 8 | High-priority sources (level) |
| src_dma_i | input | 6 | DMA sources (level) |
| src_fiq_i | input | 8 | Fast-interrupt sources (level) |
| addr_i | input | 6 | Register address: bank in [5:4], offset in [3:0] |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Combined general interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench first runs directed patterns, each aimed at one distinction:
- A single pulse on a low-priority source separates edge latching from level following.
- A partial clear word shows that only the bits written 1 are cleared.
- Writes to the status and request offsets of the level banks show that those writes are ignored.
- An all-ones mask write to the DMA bank exposes the two bits that do not exist.

Long random runs then toggle every source and write random words to random addresses, including reserved offsets. Each cycle, the read data and both outputs are compared against a behavioural model. These runs catch errors in mask gating, in bank selection and in the split of sources between the two outputs.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_BANKS = 4;
  localparam int ADDR_W    = 6;
  localparam int OFF_W     = 4;

  localparam logic [OFF_W-1:0] OFF_STAT = 4'h0;
  localparam logic [OFF_W-1:0] OFF_REQ  = 4'h4;  // read: request, write: clear
  localparam logic [OFF_W-1:0] OFF_MASK = 4'h8;

  typedef enum logic [1:0] {
    BANK_LO  = 2'd0,
    BANK_HI  = 2'd1,
    BANK_DMA = 2'd2,
    BANK_FIQ = 2'd3
  } bank_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter bit LATCHED = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] req_o
);
  localparam logic [DATA_W-1:0] VALID = DATA_W'((64'd1 << NSRC) - 64'd1);

  logic [DATA_W-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (wr_i && off_i == OFF_MASK)   mask_q <= wdata_i & VALID;
  end

  if (LATCHED) begin : g_latch
    logic [DATA_W-1:0] src_q, rise, clr;
    assign rise = src_i & ~src_q & VALID;
    assign clr  = (wr_i && off_i == OFF_REQ) ? wdata_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q    <= '0;
        status_q <= '0;
      end else begin
        src_q    <= src_i & VALID;
        status_q <= (status_q & ~clr) | rise;  // new edge wins over clear
      end
    end

    a_r5_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise != '0) |=> ((status_o & $past(rise)) == $past(rise)));
    a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && off_i == OFF_REQ) |=> ((status_o & $past(wdata_i & ~rise)) == '0));
  end else begin : g_level
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q <= '0;
      else         status_q <= src_i & VALID;
    end

    a_r7_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && off_i == OFF_REQ) |=> (status_o == $past(src_i & VALID)));
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign req_o    = status_q & mask_q;

  a_r3_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_MASK) |=> (mask_o == $past(wdata_i & VALID)));
  a_r8_stat_wr_no_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_STAT) |=> $stable(mask_o));
  a_r9_absent_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o | mask_o) & ~VALID) == '0);
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_bank_pkg::*;
(
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  status_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  mask_i,
  output logic [DATA_W-1:0]                 rdata_o
);
  logic [1:0]       bank;
  logic [OFF_W-1:0] off;
  assign bank = addr_i[ADDR_W-1:OFF_W];
  assign off  = addr_i[OFF_W-1:0];

  always_comb begin
    unique case (off)
      OFF_STAT: rdata_o = status_i[bank];
      OFF_REQ:  rdata_o = status_i[bank] & mask_i[bank];
      OFF_MASK: rdata_o = mask_i[bank];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int DMA_SRC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        src_a_i,
  input  logic [7:0]        src_b_i,
  input  logic [DMA_SRC-1:0] src_dma_i,
  input  logic [7:0]        src_fiq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int PAD = DATA_W - DMA_SRC;

  logic [NUM_BANKS-1:0][DATA_W-1:0] src_w, status_w, mask_w, req_w;

  assign src_w[BANK_LO]  = src_a_i;
  assign src_w[BANK_HI]  = src_b_i;
  assign src_w[BANK_DMA] = {{PAD{1'b0}}, src_dma_i};
  assign src_w[BANK_FIQ] = src_fiq_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank #(
      .NSRC    ((b == int'(BANK_DMA)) ? DMA_SRC : DATA_W),
      .LATCHED (b == int'(BANK_LO))
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_w[b]),
      .wr_i     (we_i && addr_i[ADDR_W-1:OFF_W] == 2'(b)),
      .off_i    (addr_i[OFF_W-1:0]),
      .wdata_i  (wdata_i),
      .status_o (status_w[b]),
      .mask_o   (mask_w[b]),
      .req_o    (req_w[b])
    );
  end

  irq_rd_mux u_rd_mux (
    .addr_i   (addr_i),
    .status_i (status_w),
    .mask_i   (mask_w),
    .rdata_o  (rdata_o)
  );

  assign irq_o = |(req_w[BANK_LO] | req_w[BANK_HI] | req_w[BANK_DMA]);
  assign fiq_o = |req_w[BANK_FIQ];

  a_r10_fiq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (mask_w[BANK_FIQ] != '0));
  a_r10_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((mask_w[BANK_LO] | mask_w[BANK_HI] | mask_w[BANK_DMA]) != '0));
endmodule

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_a = '0, src_b = '0, src_fiq = '0;
  logic [5:0] src_dma = '0;
  logic [5:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, fiq;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] m_stat [4];
  logic [7:0] m_mask [4];
  logic [7:0] m_srcq;

  always #5 clk = ~clk;

  irq_bank_ctrl u_irq_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_a_i(src_a), .src_b_i(src_b),
    .src_dma_i(src_dma), .src_fiq_i(src_fiq), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [7:0] valid_of(int b);
    return (b == 2) ? 8'h3F : 8'hFF;
  endfunction

  function automatic logic [7:0] model_read(logic [5:0] a);
    int b = int'(a[5:4]);
    case (a[3:0])
      4'h0:    return m_stat[b];
      4'h4:    return m_stat[b] & m_mask[b];
      4'h8:    return m_mask[b];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string auto_tag(logic [5:0] a);
    if (a[3:0] == 4'h4) return "R4";
    if (a[3:0] == 4'h8) return "R3";
    if (a[3:0] != 4'h0) return "R2";
    if (a[5:4] == 2'd0) return "R5";
    if (a[5:4] == 2'd2) return "R9";
    return "R7";
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(logic [7:0] sa, logic [7:0] sb, logic [5:0] sd,
                            logic [7:0] sf, logic [5:0] a, logic w, logic [7:0] d);
    logic [7:0] srcs [4];
    logic [7:0] clr;
    int bsel = int'(a[5:4]);
    srcs[0] = sa; srcs[1] = sb; srcs[2] = {2'b00, sd}; srcs[3] = sf;
    clr = (w && bsel == 0 && a[3:0] == 4'h4) ? d : 8'h00;
    m_stat[0] = (m_stat[0] & ~clr) | (sa & ~m_srcq);
    m_srcq = sa;
    for (int b = 1; b < 4; b++) m_stat[b] = srcs[b] & valid_of(b);
    if (w && a[3:0] == 4'h8) m_mask[bsel] = d & valid_of(bsel);
  endtask

  // one clock: drive at negedge, check reads/outputs, then let the edge happen
  task automatic cyc(logic [7:0] sa, logic [7:0] sb, logic [5:0] sd, logic [7:0] sf,
                     logic [5:0] a, logic w, logic [7:0] d, string tag);
    logic exp_irq, exp_fiq;
    @(negedge clk);
    src_a = sa; src_b = sb; src_dma = sd; src_fiq = sf;
    addr = a; we = w; wdata = d;
    #1;
    chk((tag == "") ? auto_tag(a) : tag, rdata, model_read(a));
    exp_irq = |((m_stat[0] & m_mask[0]) | (m_stat[1] & m_mask[1]) | (m_stat[2] & m_mask[2]));
    exp_fiq = |(m_stat[3] & m_mask[3]);
    chk("R10", {6'b0, irq, fiq}, {6'b0, exp_irq, exp_fiq});
    @(posedge clk);
    if (rst_n) model_step(sa, sb, sd, sf, a, w, d);
  endtask

  task automatic rd(logic [5:0] a, string tag);
    cyc(src_a, src_b, src_dma, src_fiq, a, 1'b0, 8'h00, tag);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d, string tag);
    cyc(src_a, src_b, src_dma, src_fiq, a, 1'b1, d, tag);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin m_stat[b] = '0; m_mask[b] = '0; end
    m_srcq = '0;

    // R1: reset state, including reads while sources toggle during reset
    for (int b = 0; b < 4; b++) begin
      cyc(8'hFF, 8'hFF, 6'h3F, 8'hFF, {2'(b), 4'h0}, 1'b1, 8'hFF, "R1");
      cyc(8'h00, 8'h00, 6'h00, 8'h00, {2'(b), 4'h8}, 1'b0, 8'h00, "R1");
    end
    @(negedge clk); rst_n = 1'b1;
    for (int b = 0; b < 4; b++) rd({2'(b), 4'h8}, "R1");

    // R3/R9: enable everything; DMA keeps only six bits
    for (int b = 0; b < 4; b++) wr({2'(b), 4'h8}, 8'hFF, "R3");
    rd(6'h28, "R9");

    // R5: a one-cycle pulse on low-priority sources stays latched
    cyc(8'h05, 8'h00, 6'h00, 8'h00, 6'h00, 1'b0, 8'h00, "R5");
    cyc(8'h00, 8'h00, 6'h00, 8'h00, 6'h00, 1'b0, 8'h00, "R5");
    rd(6'h00, "R5");
    rd(6'h04, "R4");

    // R6: clear bit 0 only, bit 2 stays
    wr(6'h04, 8'h01, "R6");
    rd(6'h00, "R6");
    wr(6'h04, 8'h04, "R6");
    rd(6'h00, "R6");

    // R7/R8: level banks, writes to status and request ignored
    cyc(8'h00, 8'h81, 6'h3F, 8'h10, 6'h10, 1'b0, 8'h00, "R7");
    cyc(8'h00, 8'h81, 6'h3F, 8'h10, 6'h14, 1'b1, 8'hFF, "R7");
    rd(6'h10, "R7");
    wr(6'h10, 8'h00, "R8");
    rd(6'h18, "R8");
    wr(6'h00, 8'h00, "R8");
    rd(6'h08, "R8");
    rd(6'h20, "R9");
    rd(6'h30, "R7");
    rd(6'h0C, "R2");
    rd(6'h31, "R2");

    // R10: fast-only and general-only
    for (int b = 0; b < 4; b++) wr({2'(b), 4'h8}, 8'h00, "R10");
    wr(6'h38, 8'h10, "R10");
    rd(6'h34, "R10");
    wr(6'h38, 8'h00, "R10");
    wr(6'h28, 8'h20, "R10");
    rd(6'h24, "R10");

    // random traffic
    for (int i = 0; i < 20000; i++) begin
      logic [5:0] a;
      logic [3:0] offs [4];
      offs[0] = 4'h0; offs[1] = 4'h4; offs[2] = 4'h8; offs[3] = 4'($urandom_range(0, 15));
      a = {2'($urandom_range(0, 3)), offs[$urandom_range(0, 3)]};
      cyc(8'($urandom), 8'($urandom), 6'($urandom), 8'($urandom),
          a, ($urandom_range(0, 3) == 0), 8'($urandom), "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule